// File: doc/BRIEF.md
# Serial Byte Receiver with Held Output Handshake

This block turns an asynchronous serial line into bytes. The line rests high. A falling edge starts a frame. The receiver confirms the start bit half a bit period later. It then samples every following bit once per bit period. It collects the data bits least significant bit first. When parity is enabled, it checks an odd parity bit. Last, it checks that the stop bit is high. The bit period is a fixed number of clocks, set by a parameter.

A byte that arrives with no error is placed on a valid/accept output. The data and the valid flag stay unchanged until the consumer raises accept. The consumer may raise accept whenever it is ready, and it only needs to hold accept high for one cycle. A byte with a parity or framing error is never shown as valid. Instead the receiver reports it with a one-cycle pulse on a separate error output. The serial input passes through a two-stage synchronizer before edge detection, so it may come from another clock domain.

Top module: `uart_rx_hold`

## Requirements
- R1: While `rst_n` is low, and just after it is released, `rx_valid`, `err_parity` and `err_frame` are 0.
- R2: A frame starts on a high-to-low change of the synchronized line. The start bit is checked `CLK_DIV/2` clocks later. If the line reads 1 at that point, the receiver returns to idle. It then produces no byte and no error.
- R3: Each bit after the start bit is sampled `CLK_DIV` clocks after the previous sample. The first data bit received is bit 0 of `rx_data`.
- R4: With `PARITY_EN=1`, the bit after the data is a parity bit. The data bits and the parity bit together must hold an odd number of ones. If they do not, `err_parity` pulses high for exactly one cycle and no byte is presented.
- R5: A stop bit read as 0 makes `err_frame` pulse high for exactly one cycle, and no byte is presented. Whenever an error pulse occurs, `rx_valid` does not rise.
- R6: While `rx_valid` is 1 and `rx_accept` is 0, `rx_valid` stays 1 and `rx_data` does not change.
- R7: When `rx_valid` and `rx_accept` are both 1 on a clock edge, `rx_valid` is 0 in the next cycle, unless a new good byte completes on that same edge.
- R8: If a good byte completes while an earlier byte is still waiting for accept, the new byte is dropped. The held byte stays on `rx_data`.
- R9: Frames that follow each other with no idle time between a stop bit and the next start bit are each received.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| rx_line | input | 1 | Serial input, high when idle |
| rx_data | output | DATA_BITS | Received byte, held while valid |
| rx_valid | output | 1 | A byte is waiting on `rx_data` |
| rx_accept | input | 1 | Consumer takes the byte (one-cycle pulse is enough) |
| err_parity | output | 1 | One-cycle pulse: parity check failed |
| err_frame | output | 1 | One-cycle pulse: stop bit was 0 |

## Verification
The hardest case to reach from the ports is a second good byte that completes while the first one is still waiting for accept. The consumer must stall for more than a whole frame time, and the serial driver must keep sending during that stall. The bench makes this happen by setting a very long acceptance delay in its consumer process. It then sends two frames back to back and expects only the first byte. The rejected start bit is another hard case. The bench creates it with a low pulse shorter than half a bit period. It then checks that no byte and no error appear.

// File: rtl/uart_rx_hold.sv
module uart_rx_hold #(
  parameter int CLK_DIV   = 10,
  parameter int DATA_BITS = 8,
  parameter bit PARITY_EN = 1'b1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 rx_line,
  output logic [DATA_BITS-1:0] rx_data,
  output logic                 rx_valid,
  input  logic                 rx_accept,
  output logic                 err_parity,
  output logic                 err_frame
);
  localparam int CW   = (CLK_DIV > 2) ? $clog2(CLK_DIV) : 1;
  localparam int IW   = $clog2(DATA_BITS + 1);
  localparam int HALF = CLK_DIV / 2;

  typedef enum logic [2:0] {S_IDLE, S_START, S_DATA, S_PAR, S_STOP} state_t;

  state_t               state;
  logic [1:0]           sync;
  logic                 line_q;
  logic [CW-1:0]        cnt;
  logic [IW-1:0]        bidx;
  logic [DATA_BITS-1:0] shreg;
  logic                 par_ok;
  logic                 line, fall, tick, done, good;

  assign line = sync[1];
  assign fall = line_q & ~line;
  assign tick = (cnt == '0);
  assign done = (state == S_STOP) && tick;
  assign good = done & line & par_ok;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync   <= 2'b11;
      line_q <= 1'b1;
    end else begin
      sync   <= {sync[0], rx_line};
      line_q <= line;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= S_IDLE;
      cnt   <= '0;
      bidx  <= '0;
      shreg <= '0;
    end else if (state == S_IDLE) begin
      if (fall) begin
        state <= S_START;
        cnt   <= CW'(HALF - 1);
      end
    end else if (!tick) begin
      cnt <= cnt - 1'b1;
    end else begin
      cnt <= CW'(CLK_DIV - 1);
      case (state)
        S_START: begin
          bidx  <= '0;
          state <= line ? S_IDLE : S_DATA;
        end
        S_DATA: begin
          shreg <= {line, shreg[DATA_BITS-1:1]};
          bidx  <= bidx + 1'b1;
          if (bidx == IW'(DATA_BITS - 1))
            state <= PARITY_EN ? S_PAR : S_STOP;
        end
        S_PAR:   state <= S_STOP;
        default: state <= S_IDLE;
      endcase
    end
  end

  generate
    if (PARITY_EN) begin : g_par
      logic par_bit;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
          par_bit <= 1'b1;
        else if (state == S_PAR && tick)
          par_bit <= line;
      end
      assign par_ok = ^{shreg, par_bit};
    end else begin : g_nopar
      assign par_ok = 1'b1;
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      err_parity <= 1'b0;
      err_frame  <= 1'b0;
      rx_valid   <= 1'b0;
      rx_data    <= '0;
    end else begin
      err_parity <= done & ~par_ok;
      err_frame  <= done & ~line;
      if (good && (!rx_valid || rx_accept)) begin
        rx_data  <= shreg;
        rx_valid <= 1'b1;
      end else if (rx_accept) begin
        rx_valid <= 1'b0;
      end
    end
  end

  p_hold_stable_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid && !rx_accept |=> rx_valid && $stable(rx_data));

  p_release_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid && rx_accept && !good |=> !rx_valid);

  p_no_valid_on_error_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (err_parity || err_frame) |-> !$rose(rx_valid));

  p_parity_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
    err_parity |=> !err_parity);

  p_frame_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
    err_frame |=> !err_frame);
endmodule

// File: tb/test_uart_rx_hold.sv
module test_uart_rx_hold;
  localparam int DIV = 10;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       rx_line;
  logic [7:0] rx_data;
  logic       rx_valid;
  logic       rx_accept;
  logic       err_parity;
  logic       err_frame;

  int checks = 0;
  int errors = 0;
  int accept_delay = 0;
  int exp_kind[$];
  logic [7:0] exp_data[$];

  always #2 clk = ~clk;

  uart_rx_hold #(.CLK_DIV(DIV), .DATA_BITS(8), .PARITY_EN(1'b1)) i_uart_rx_hold (
    .clk(clk), .rst_n(rst_n), .rx_line(rx_line), .rx_data(rx_data),
    .rx_valid(rx_valid), .rx_accept(rx_accept),
    .err_parity(err_parity), .err_frame(err_frame));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic drive_bit(input logic b);
    rx_line = b;
    repeat (DIV) @(negedge clk);
  endtask

  // kind: 0 good byte, 1 parity error, 2 framing error, -1 none expected
  task automatic send_frame(input logic [7:0] d, input bit bad_par, input bit stop_val, input bit push);
    if (push) begin
      exp_kind.push_back(!stop_val ? 2 : (bad_par ? 1 : 0));
      exp_data.push_back(d);
    end
    drive_bit(1'b0);
    for (int i = 0; i < 8; i++) drive_bit(d[i]);
    drive_bit(~^d ^ bad_par);
    drive_bit(stop_val);
    rx_line = 1'b1;
  endtask

  task automatic take_event(input int kind, input logic [7:0] d, input string req);
    if (exp_kind.size() == 0) begin
      chk(1'b0, {req, " unexpected event"}, kind, -1);
    end else begin
      int k;
      logic [7:0] e;
      k = exp_kind.pop_front();
      e = exp_data.pop_front();
      chk(k == kind, {req, " event kind"}, kind, k);
      if (kind == 0 && k == 0) chk(d == e, "R3 byte value", d, e);
    end
  endtask

  // monitor and consumer
  initial begin
    bit have = 0;
    bit acc_sent = 0;
    int hold_cnt = 0;
    logic [7:0] held = '0;
    rx_accept = 1'b0;
    forever begin
      @(negedge clk);
      if (rst_n) begin
        if (err_parity) take_event(1, 8'h00, "R4");
        if (err_frame)  take_event(2, 8'h00, "R5");
        if (acc_sent) begin
          rx_accept = 1'b0;
          acc_sent  = 0;
          have      = 0;
          chk(rx_valid == 1'b0, "R7 valid after accept", rx_valid, 0);
        end else if (rx_valid) begin
          if (!have) begin
            take_event(0, rx_data, "R3");
            have = 1;
            held = rx_data;
            hold_cnt = 0;
          end else begin
            chk(rx_data == held, "R6 data held", rx_data, held);
          end
          hold_cnt++;
          if (hold_cnt > accept_delay) begin
            rx_accept = 1'b1;
            acc_sent  = 1;
          end
        end
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL R1 watchdog actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    rx_line = 1'b1;
    rst_n   = 1'b0;
    repeat (5) @(negedge clk);
    chk(!rx_valid && !err_parity && !err_frame, "R1 in reset", {rx_valid, err_parity, err_frame}, 0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    chk(!rx_valid && !err_parity && !err_frame, "R1 after reset", {rx_valid, err_parity, err_frame}, 0);

    accept_delay = 0;
    send_frame(8'hA5, 0, 1, 1); drive_bit(1'b1);
    accept_delay = 3;
    send_frame(8'h00, 0, 1, 1); drive_bit(1'b1);
    send_frame(8'hFF, 0, 1, 1); drive_bit(1'b1);
    accept_delay = 1;
    send_frame(8'h01, 0, 1, 1); drive_bit(1'b1);
    send_frame(8'h80, 0, 1, 1); drive_bit(1'b1);

    send_frame(8'h3C, 1, 1, 1); drive_bit(1'b1);
    send_frame(8'h5A, 0, 0, 1); drive_bit(1'b1); drive_bit(1'b1);

    // R2: short low pulse rejected at the half-bit check
    rx_line = 1'b0;
    repeat (2) @(negedge clk);
    rx_line = 1'b1;
    repeat (3 * DIV) @(negedge clk);
    chk(!rx_valid && exp_kind.size() == 0, "R2 glitch ignored", {rx_valid, 7'(exp_kind.size())}, 0);
    send_frame(8'hC3, 0, 1, 1); drive_bit(1'b1);

    // R9: back to back
    accept_delay = 0;
    send_frame(8'h12, 0, 1, 1);
    send_frame(8'h34, 0, 1, 1);
    send_frame(8'h56, 0, 1, 1);
    drive_bit(1'b1);

    // R8: stalled consumer, second byte dropped
    accept_delay = 400;
    send_frame(8'h11, 0, 1, 1);
    send_frame(8'h22, 0, 1, 0);
    repeat (5) @(negedge clk);
    chk(rx_valid && rx_data == 8'h11, "R8 held byte kept", rx_data, 8'h11);
    repeat (500) @(negedge clk);
    accept_delay = 0;

    send_frame(8'h9E, 0, 1, 1);
    repeat (3 * DIV) @(negedge clk);
    chk(exp_kind.size() == 0, "R9 all expected items seen", exp_kind.size(), 0);
    chk(!rx_valid, "R7 idle at end", rx_valid, 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule